// File: doc/BRIEF.md
# DMA Request Local Arbiter

This block lets four DMA request sources share one requester on a system bus that uses priority arbitration. The four sources are receive-ready and transmit-ready for each of two serial channels. When no transfer is in progress, the block picks one pending request and latches its 2-bit source code. It then waits for the next arbitration cycle. During that cycle it puts the 4-bit arbitration vector programmed for that source onto the arbitration bus.

If the block wins the bus, it moves through a one-cycle setup step and then a transfer step. In the transfer step it acknowledges the source and holds burst for as long as the source keeps requesting. A preempt from another bus master ends the burst early and sends the machine back to compete again.

Every bus-facing output comes with an output-enable, so that an outer wrapper can model open or tri-state drivers. The per-source vectors come in on a configuration input. The actual bit contention on the arbitration lines and the serial channels themselves sit outside the block.

Top module: `dma_arb`

## Requirements
- R1: `req_i` bit 0 is receive-ready of channel 1 (code 0), bit 1 is transmit-ready of channel 1 (code 1), bit 2 is receive-ready of channel 2 (code 2) and bit 3 is transmit-ready of channel 2 (code 3). The vector for code k is `vec_cfg_i[4k+3:4k]`.
- R2: When several requests are pending in idle, the code chosen follows the order channel-1 receive, channel-2 receive, channel-1 transmit, channel-2 transmit. `sel_o` is latched on leaving idle and is held constant until the machine is idle again.
- R3: After a request is latched, `preempt_oe_o` and `preempt_o` are high. The machine waits with `vec_oe_o` low until `arb_i` goes high.
- R4: While `arb_i` is high in the arbitration step, `vec_oe_o` is high and `vec_o` equals the selected vector. At all other times `vec_oe_o` is low and `vec_o` is zero.
- R5: When `arb_i` falls with `won_i` high, the machine spends exactly one cycle in a setup step and then enters the transfer step. When `arb_i` falls with `won_i` low, it returns to waiting with preempt still driven.
- R6: `ack_o`, `burst_o` and `burst_oe_o` are high only in the transfer step. `preempt_oe_o` is low in the setup and transfer steps.
- R7: The transfer step lasts while the selected request stays high and `preempt_i` is low. When the selected request drops, the machine goes to idle on the next clock.
- R8: `preempt_i` in the transfer step, with the selected request still high, returns the machine to the waiting step with the same code. If the request has also dropped, the machine goes to idle.
- R9: `chan_rst_i` is synchronous. It puts the machine in idle on the next clock, clears every enable and `ack_o`, overrides all other inputs, and no request is taken while it is high.
- R10: While `rst_ni` is low, the machine is idle, every output is zero and `sel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_rst_i | input | 1 | Synchronous channel reset |
| req_i | input | 4 | DMA request lines, one per source |
| vec_cfg_i | input | 16 | Four 4-bit arbitration vectors, code k at bits 4k+3:4k |
| arb_i | input | 1 | High during a bus arbitration cycle |
| won_i | input | 1 | Bus won, valid when arb_i falls |
| preempt_i | input | 1 | Another master requests the bus |
| vec_o | output | 4 | Arbitration vector value |
| vec_oe_o | output | 1 | Drive enable for vec_o |
| sel_o | output | 2 | Latched source code |
| ack_o | output | 1 | Acknowledge to the selected source |
| burst_o | output | 1 | Burst value |
| burst_oe_o | output | 1 | Drive enable for burst_o |
| preempt_o | output | 1 | Preempt request value |
| preempt_oe_o | output | 1 | Drive enable for preempt_o |

## Verification
On every cycle the assertions check that the source code stays fixed for the whole of a transaction. They also check that acknowledge and burst appear only after a setup cycle, and that preempt, vector and burst are never driven at the same time. Finally, they check that a channel reset clears every driver within one clock. The bench's scenarios cover what a property cannot: the priority order under mixed request patterns, the exact vector value taken from the configuration word, the return to waiting after a lost arbitration, and the two exits out of the transfer step after a preempt.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_ARB  = 3'd2,
    ST_XFR1 = 3'd3,
    ST_XFR2 = 3'd4
  } arb_st_e;
endpackage

// File: rtl/dma_req_pick.sv
module dma_req_pick #(
  parameter int NSRC  = 4,
  parameter int SEL_W = 2
) (
  input  logic [NSRC-1:0]  req_i,
  output logic             any_o,
  output logic [SEL_W-1:0] code_o
);
  localparam int HALF = NSRC / 2;

  // all receive sources rank above all transmit sources, lower channel first
  always_comb begin
    any_o  = |req_i;
    code_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      int idx;
      idx = (i < HALF) ? 2 * i : 2 * (i - HALF) + 1;
      if (req_i[idx]) code_o = SEL_W'(idx);
    end
  end
endmodule

// File: rtl/dma_vec_sel.sv
module dma_vec_sel #(
  parameter int NSRC  = 4,
  parameter int VEC_W = 4,
  parameter int SEL_W = 2
) (
  input  logic [NSRC*VEC_W-1:0] cfg_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic                  en_i,
  output logic [VEC_W-1:0]      vec_o
);
  logic [VEC_W-1:0] slot [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_slot
    assign slot[g] = cfg_i[g*VEC_W +: VEC_W];
  end

  assign vec_o = en_i ? slot[sel_i] : '0;
endmodule

// File: rtl/dma_arb_seq.sv
module dma_arb_seq
  import dma_arb_pkg::*;
#(
  parameter int NSRC  = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chan_rst_i,
  input  logic [NSRC-1:0]  req_i,
  input  logic             any_req_i,
  input  logic [SEL_W-1:0] pick_i,
  input  logic             arb_i,
  input  logic             won_i,
  input  logic             preempt_i,
  output arb_st_e          st_o,
  output logic [SEL_W-1:0] sel_o
);
  arb_st_e          st_q, st_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             sel_live;

  assign sel_live = req_i[sel_q];

  always_comb begin
    st_d  = st_q;
    sel_d = sel_q;
    unique case (st_q)
      ST_IDLE: if (any_req_i) begin
        st_d  = ST_REQ;
        sel_d = pick_i;
      end
      ST_REQ:  if (arb_i) st_d = ST_ARB;
      ST_ARB:  if (!arb_i) st_d = won_i ? ST_XFR1 : ST_REQ;
      ST_XFR1: st_d = ST_XFR2;
      ST_XFR2: begin
        if (!sel_live)     st_d = ST_IDLE;
        else if (preempt_i) st_d = ST_REQ;
      end
      default: st_d = ST_IDLE;
    endcase
    if (chan_rst_i) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sel_q <= '0;
    end else begin
      st_q  <= st_d;
      sel_q <= sel_d;
    end
  end

  assign st_o  = st_q;
  assign sel_o = sel_q;
endmodule

// File: rtl/dma_arb.sv
module dma_arb
  import dma_arb_pkg::*;
#(
  parameter int NSRC  = 4,
  parameter int VEC_W = 4,
  localparam int SEL_W = $clog2(NSRC)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  chan_rst_i,
  input  logic [NSRC-1:0]       req_i,
  input  logic [NSRC*VEC_W-1:0] vec_cfg_i,
  input  logic                  arb_i,
  input  logic                  won_i,
  input  logic                  preempt_i,
  output logic [VEC_W-1:0]      vec_o,
  output logic                  vec_oe_o,
  output logic [SEL_W-1:0]      sel_o,
  output logic                  ack_o,
  output logic                  burst_o,
  output logic                  burst_oe_o,
  output logic                  preempt_o,
  output logic                  preempt_oe_o
);
  logic             any_req;
  logic [SEL_W-1:0] pick;
  arb_st_e          st;
  logic             in_xfr2;
  logic             pre_en;

  dma_req_pick #(.NSRC(NSRC), .SEL_W(SEL_W)) u_pick (
    .req_i  (req_i),
    .any_o  (any_req),
    .code_o (pick)
  );

  dma_arb_seq #(.NSRC(NSRC), .SEL_W(SEL_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chan_rst_i (chan_rst_i),
    .req_i      (req_i),
    .any_req_i  (any_req),
    .pick_i     (pick),
    .arb_i      (arb_i),
    .won_i      (won_i),
    .preempt_i  (preempt_i),
    .st_o       (st),
    .sel_o      (sel_o)
  );

  assign vec_oe_o = (st == ST_ARB);

  dma_vec_sel #(.NSRC(NSRC), .VEC_W(VEC_W), .SEL_W(SEL_W)) u_vec (
    .cfg_i (vec_cfg_i),
    .sel_i (sel_o),
    .en_i  (vec_oe_o),
    .vec_o (vec_o)
  );

  assign in_xfr2      = (st == ST_XFR2);
  assign pre_en       = (st == ST_REQ) || (st == ST_ARB);
  assign ack_o        = in_xfr2;
  assign burst_o      = in_xfr2;
  assign burst_oe_o   = in_xfr2;
  assign preempt_o    = pre_en;
  assign preempt_oe_o = pre_en;
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk
  import dma_arb_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chan_rst_i,
  input arb_st_e          st,
  input logic [SEL_W-1:0] sel_o,
  input logic             vec_oe_o,
  input logic             ack_o,
  input logic             burst_oe_o,
  input logic             preempt_oe_o
);
  a_r2_sel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(sel_o));

  a_r5_setup_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(st) == ST_XFR1);

  a_r6_ack_in_xfr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (burst_oe_o && st == ST_XFR2));

  a_r6_drivers_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({vec_oe_o, burst_oe_o, (preempt_oe_o && !vec_oe_o)}) <= 1);

  a_r6_no_pre_in_xfr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !preempt_oe_o);

  a_r9_chan_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(chan_rst_i) |-> (!vec_oe_o && !burst_oe_o && !preempt_oe_o && !ack_o));
endmodule

bind dma_arb dma_arb_chk #(.SEL_W(SEL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .chan_rst_i   (chan_rst_i),
  .st           (st),
  .sel_o        (sel_o),
  .vec_oe_o     (vec_oe_o),
  .ack_o        (ack_o),
  .burst_oe_o   (burst_oe_o),
  .preempt_oe_o (preempt_oe_o)
);

// File: tb/tb_dma_arb.sv
module tb_dma_arb;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        chan_rst_i = 0;
  logic [3:0]  req_i = '0;
  logic [15:0] vec_cfg_i = 16'hB7D2;
  logic        arb_i = 0, won_i = 0, preempt_i = 0;
  logic [3:0]  vec_o;
  logic        vec_oe_o, ack_o, burst_o, burst_oe_o, preempt_o, preempt_oe_o;
  logic [1:0]  sel_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  dma_arb dut (.*);

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  function automatic logic [3:0] vec_of(input int code);
    return vec_cfg_i[code*4 +: 4];
  endfunction

  task automatic clear();
    chan_rst_i = 1; req_i = '0; arb_i = 0; won_i = 0; preempt_i = 0;
    tick();
    chan_rst_i = 0;
  endtask

  task automatic t_reset();
    chk("R10", "sel", sel_o, 0);
    chk("R10", "enables", {vec_oe_o, burst_oe_o, preempt_oe_o, ack_o}, 0);
    chk("R10", "values", {vec_o, burst_o, preempt_o}, 0);
  endtask

  task automatic t_prio(input logic [3:0] r, input int exp);
    req_i = r;
    tick();
    chk("R2", $sformatf("pick for %b", r), sel_o, exp);
    chk("R3", "preempt driven", {preempt_oe_o, preempt_o}, 3);
    chk("R3", "vector idle", vec_oe_o, 0);
    clear();
  endtask

  task automatic go_xfr2(input int code);
    req_i = 4'(1 << code);
    tick();
    tick();
    chk("R3", "waits for arb", {preempt_oe_o, vec_oe_o}, 2);
    arb_i = 1;
    tick();
    chk("R4", "vec enable", vec_oe_o, 1);
    chk("R1", $sformatf("vector code %0d", code), vec_o, vec_of(code));
    chk("R1", "code", sel_o, code);
    arb_i = 0; won_i = 1;
    tick();
    won_i = 0;
    chk("R5", "setup no ack", ack_o, 0);
    chk("R6", "setup preempt released", preempt_oe_o, 0);
    chk("R4", "vec off", {vec_oe_o, vec_o}, 0);
    tick();
    chk("R6", "xfr ack/burst", {ack_o, burst_o, burst_oe_o}, 7);
    chk("R6", "xfr preempt off", preempt_oe_o, 0);
  endtask

  task automatic t_xfer(input int code);
    go_xfr2(code);
    tick();
    chk("R7", "holds burst", ack_o, 1);
    req_i = '0;
    tick();
    chk("R7", "idle after drop", {ack_o, burst_oe_o, preempt_oe_o}, 0);
  endtask

  task automatic t_lost();
    req_i = 4'b0100;
    tick();
    arb_i = 1;
    tick();
    chk("R4", "vec rx2", vec_o, vec_of(2));
    arb_i = 0; won_i = 0;
    tick();
    chk("R5", "lost back to wait", {preempt_oe_o, vec_oe_o, ack_o}, 4);
    chk("R5", "code kept", sel_o, 2);
    clear();
  endtask

  task automatic t_preempt();
    go_xfr2(1);
    req_i = 4'b0011;
    preempt_i = 1;
    tick();
    preempt_i = 0;
    chk("R8", "rearb wait", {preempt_oe_o, ack_o}, 2);
    chk("R8", "same code", sel_o, 1);
    clear();
    go_xfr2(3);
    req_i = '0; preempt_i = 1;
    tick();
    preempt_i = 0;
    chk("R8", "idle when dropped", {preempt_oe_o, ack_o}, 0);
    clear();
  endtask

  task automatic t_chan_rst();
    go_xfr2(0);
    chan_rst_i = 1;
    tick();
    chk("R9", "cleared", {vec_oe_o, burst_oe_o, preempt_oe_o, ack_o}, 0);
    req_i = 4'b1111;
    tick();
    chk("R9", "ignores req", preempt_oe_o, 0);
    chan_rst_i = 0;
    tick();
    chk("R9", "resumes", preempt_oe_o, 1);
    clear();
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick();
    t_reset();
    rst_ni = 1;
    tick();
    t_reset();
    t_prio(4'b1111, 0);
    t_prio(4'b1110, 2);
    t_prio(4'b1010, 1);
    t_prio(4'b1000, 3);
    t_prio(4'b0110, 2);
    for (int c = 0; c < 4; c++) t_xfer(c);
    t_lost();
    t_preempt();
    t_chan_rst();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule